// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked request port and an external asynchronous static RAM of 512K sixteen-bit words. A requester presents a word address, write data, a two-bit lane mask and a read/write flag under a valid/ready handshake. The block then drives the memory's two chip selects (one active low, one active high), its output and write strobes and its per-lane enables. It holds every phase for a whole number of clock cycles, and each count comes from a nanosecond figure divided by the clock period.

The memory's data bus is split at the block's edge into an output word, an output-enable and an input word, so that the pad cell which joins them stays outside the block. The controller drives the bus only while the memory cannot. Read data is captured inside the access window and returned with a one-cycle done pulse. Only one access is in flight at a time.

Phase length in cycles is ceil(ns / CLK_NS), with a floor of one. With the default 8 ns clock the write strobe lasts 6 cycles, write recovery 1 cycle, read access 7 cycles and read release 3 cycles.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the memory is deselected (ce1_n high, ce2 low), mem_we_n and mem_oe_n are high, mem_dq_oe is low, req_ready is high and rsp_done is low.
- R2: The memory is selected (ce1_n low and ce2 high together) only during the write strobe, the write hold cycle and the read access window. Whenever either strobe is low, the memory is selected.
- R3: The write strobe mem_we_n stays low for N_WP cycles. N_WP is the largest of the cycle counts for strobe width, address setup to strobe end and data setup to strobe end. Address and lane enables stay stable while the strobe is low.
- R4: mem_dq_oe is high for the whole write strobe and for one cycle after mem_we_n rises, and low at all other times. Mask bit 0 enables lane 0 (mem_be_n[0], data bits 7..0) and mask bit 1 enables lane 1 (mem_be_n[1], bits 15..8). The enables are active low. A lane whose mask bit is 0 is not written.
- R5: mem_dq_oe is never high while mem_oe_n is low. It is also never high within N_RGAP cycles after mem_oe_n rises, where N_RGAP is the cycle count of the output turn-off time.
- R6: A read holds mem_oe_n low and mem_we_n high for N_RD cycles. N_RD is the largest of the cycle counts for read cycle, address-to-data and output-enable-to-data. The bus is captured at the end of the last of these cycles.
- R7: rsp_rdata carries the captured lanes whose mask bit is 1. Lanes whose mask bit is 0 read as zero.
- R8: req_ready is high exactly when the block is idle. A request is taken when req_valid and req_ready are both high, and req_ready is low from then until done.
- R9: rsp_done is a one-cycle pulse. It is seen N_WP + N_WGAP + 2 cycles after a write is accepted and N_RD + N_RGAP + 1 cycles after a read is accepted, counting the acceptance cycle as the first.
- R10: After the write hold cycle the memory stays deselected for N_WGAP = max(1, ceil(write cycle / CLK_NS) - N_WP - 1) cycles. This keeps the write cycle time and gives the bus an idle turnaround cycle before any following read.
- R11: The phase counter counts down by one each cycle unless it is being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit i enables byte lane i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid from done onward |
| mem_addr | output | 19 | Memory address pins |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Byte lane enables, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The assertions assume that reset is held high for at least one clock edge before checking starts. They also assume that request fields stay meaningful only in the cycle they are accepted, and that the memory drives mem_dq_in only while it is selected with mem_oe_n low and mem_we_n high. The bench's memory model drives the bus only under exactly those conditions. Until the full address-to-data delay has passed it drives a marker value, so a capture taken too early returns wrong data. The bench drives request fields at the falling edge and drops req_valid after the accepting edge, so no request changes inside the edge that accepts it.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WPULSE = 3'd1,
        PH_WHOLD  = 3'd2,
        PH_WGAP   = 3'd3,
        PH_RACC   = 3'd4,
        PH_RGAP   = 3'd5
    } phase_e;

    // Cycles needed to cover a nanosecond figure, never fewer than one.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

    p_count_down_r11: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int AW     = 19,
    parameter int DW     = 16,
    parameter int LANES  = 2,
    parameter int TW     = 4,
    parameter int N_WP   = 6,
    parameter int N_WGAP = 1,
    parameter int N_RD   = 7,
    parameter int N_RGAP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    input  logic             tmr_last,
    output logic             req_ready,
    output logic             rsp_done,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             cap_en,
    output phase_e           phase,
    output logic [AW-1:0]    cur_addr,
    output logic [DW-1:0]    cur_wdata,
    output logic [LANES-1:0] cur_mask
);
    phase_e ph_q, ph_d;
    logic   accept;
    logic   done_q;

    assign req_ready = (ph_q == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ph_q)
            PH_IDLE: if (accept) begin
                tmr_load = 1'b1;
                if (req_write) begin
                    ph_d    = PH_WPULSE;
                    tmr_val = TW'(N_WP - 1);
                end else begin
                    ph_d    = PH_RACC;
                    tmr_val = TW'(N_RD - 1);
                end
            end
            PH_WPULSE: if (tmr_last) begin
                ph_d     = PH_WHOLD;
                tmr_load = 1'b1;
                tmr_val  = '0;
            end
            PH_WHOLD: begin
                ph_d     = PH_WGAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(N_WGAP - 1);
            end
            PH_WGAP: if (tmr_last) ph_d = PH_IDLE;
            PH_RACC: if (tmr_last) begin
                ph_d     = PH_RGAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(N_RGAP - 1);
            end
            PH_RGAP: if (tmr_last) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    assign cap_en = (ph_q == PH_RACC) && tmr_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            done_q    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_mask  <= '0;
        end else begin
            ph_q   <= ph_d;
            done_q <= (ph_q != PH_IDLE) && (ph_d == PH_IDLE);
            if (accept) begin
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                cur_mask  <= req_mask;
            end
        end
    end

    assign phase    = ph_q;
    assign rsp_done = done_q;

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready);

endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
    import sramc_pkg::*;
#(
    parameter int AW     = 19,
    parameter int DW     = 16,
    parameter int LANES  = 2,
    parameter int N_WP   = 6,
    parameter int N_RGAP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             cap_en,
    input  logic [AW-1:0]    cur_addr,
    input  logic [DW-1:0]    cur_wdata,
    input  logic [LANES-1:0] cur_mask,
    input  logic [DW-1:0]    mem_dq_in,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_ce1_n,
    output logic             mem_ce2,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [LANES-1:0] mem_be_n,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    output logic [DW-1:0]    rsp_rdata
);
    localparam int LW = DW / LANES;
    localparam int CW = $clog2(N_WP + N_RGAP + 2);

    logic sel;

    assign sel        = (phase == PH_WPULSE) || (phase == PH_WHOLD) || (phase == PH_RACC);
    assign mem_ce1_n  = !sel;
    assign mem_ce2    = sel;
    assign mem_we_n   = (phase != PH_WPULSE);
    assign mem_oe_n   = (phase != PH_RACC);
    assign mem_be_n   = sel ? ~cur_mask : '1;
    assign mem_addr   = cur_addr;
    assign mem_dq_oe  = (phase == PH_WPULSE) || (phase == PH_WHOLD);
    assign mem_dq_out = cur_wdata;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                rsp_rdata[l*LW +: LW] <= '0;
            else if (cap_en)
                rsp_rdata[l*LW +: LW] <= cur_mask[l] ? mem_dq_in[l*LW +: LW] : '0;
        end
    end

    // Checker counters: strobe width and time since output enable released.
    logic [CW-1:0] we_cnt_q;
    logic [CW-1:0] oe_rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_cnt_q <= '0;
            oe_rel_q <= CW'(N_RGAP);
        end else begin
            we_cnt_q <= mem_we_n ? '0 : we_cnt_q + 1'b1;
            if (!mem_oe_n)
                oe_rel_q <= '0;
            else if (oe_rel_q < CW'(N_RGAP))
                oe_rel_q <= oe_rel_q + 1'b1;
        end
    end

    p_select_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce1_n && mem_ce2));
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
    p_strobe_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_cnt_q >= CW'(N_WP)));
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);
    p_no_clash_r5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    p_release_gap_r5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (oe_rel_q >= CW'(N_RGAP)));
    p_read_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 8,
    parameter int T_RC_NS   = 55,
    parameter int T_AA_NS   = 55,
    parameter int T_DOE_NS  = 25,
    parameter int T_HZOE_NS = 20,
    parameter int T_WC_NS   = 55,
    parameter int T_WP_NS   = 45,
    parameter int T_AW_NS   = 45,
    parameter int T_DW_NS   = 25
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_mask,
    output logic                   rsp_done,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_ce1_n,
    output logic                   mem_ce2,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic [DATA_W/8-1:0]    mem_be_n,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    localparam int LANES  = DATA_W / 8;
    localparam int N_WP   = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                 ns2cyc(T_DW_NS, CLK_NS));
    localparam int N_WGAP = imax(1, ns2cyc(T_WC_NS, CLK_NS) - N_WP - 1);
    localparam int N_RD   = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                 ns2cyc(T_DOE_NS, CLK_NS));
    localparam int N_RGAP = ns2cyc(T_HZOE_NS, CLK_NS);
    localparam int N_TOP  = imax(imax(N_WP, N_WGAP), imax(N_RD, N_RGAP));
    localparam int TW     = $clog2(N_TOP + 1);

    phase_e            phase;
    logic              tmr_load, tmr_last, cap_en;
    logic [TW-1:0]     tmr_val;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;
    logic [LANES-1:0]  cur_mask;

    sramc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sramc_seq #(
        .AW(ADDR_W), .DW(DATA_W), .LANES(LANES), .TW(TW),
        .N_WP(N_WP), .N_WGAP(N_WGAP), .N_RD(N_RD), .N_RGAP(N_RGAP)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .tmr_last  (tmr_last),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .cap_en    (cap_en),
        .phase     (phase),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_mask  (cur_mask)
    );

    sramc_pins #(
        .AW(ADDR_W), .DW(DATA_W), .LANES(LANES), .N_WP(N_WP), .N_RGAP(N_RGAP)
    ) u_pins (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .cap_en     (cap_en),
        .cur_addr   (cur_addr),
        .cur_wdata  (cur_wdata),
        .cur_mask   (cur_mask),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_ce1_n  (mem_ce1_n),
        .mem_ce2    (mem_ce2),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_be_n   (mem_be_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .rsp_rdata  (rsp_rdata)
    );

    p_wait_phase_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_dq_oe) |-> mem_ce1_n);

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int CLKP = 8;
    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLKP - 1) / CLKP;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_WP   = (cyc(45) > cyc(25)) ? cyc(45) : cyc(25);
    localparam int E_WGAP = (cyc(55) - E_WP - 1 > 1) ? cyc(55) - E_WP - 1 : 1;
    localparam int E_RD   = (cyc(55) > cyc(25)) ? cyc(55) : cyc(25);
    localparam int E_RGAP = cyc(20);
    localparam int E_WLAT = E_WP + E_WGAP + 2;
    localparam int E_RLAT = E_RD + E_RGAP + 1;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'h0;

    int total = 0, bad = 0, cycles = 0;

    always #4 clk = ~clk;

    sram_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // Memory model and pin-timing monitors, evaluated mid-cycle.
    logic [15:0] mem [int];
    logic        p_we_n = 1, p_dq_oe = 0;
    logic [1:0]  p_be_n = 2'b11;
    logic [18:0] p_addr = '0;
    logic [15:0] p_dq = '0;
    int          rd_cnt = 0, we_cnt = 0, oe_rel = 100;

    always @(negedge clk) begin
        if (!rst) begin
            logic sel;
            logic [15:0] w;
            sel = !mem_ce1_n && mem_ce2;
            if (mem_ce1_n != !mem_ce2)
                chk(0, "R2 select pair", {mem_ce1_n, mem_ce2}, 2'b01);
            if ((!mem_we_n || !mem_oe_n) && !sel)
                chk(0, "R2 strobe outside select", {mem_we_n, mem_oe_n}, 2'b11);
            if (mem_dq_oe && (!mem_oe_n || oe_rel < E_RGAP))
                chk(0, "R5 bus clash", oe_rel, E_RGAP);
            if (!mem_we_n && !p_we_n && (mem_addr != p_addr || mem_be_n != p_be_n))
                chk(0, "R3 addr stable", mem_addr, p_addr);
            if (!mem_we_n && !mem_dq_oe)
                chk(0, "R4 drive in strobe", mem_dq_oe, 1);
            if (mem_dq_oe && mem_we_n && p_we_n)
                chk(0, "R4 drive outside window", mem_dq_oe, 0);
            if (!p_we_n && mem_we_n) begin
                chk(we_cnt == E_WP, "R3 strobe width", we_cnt, E_WP);
                chk(mem_dq_oe, "R4 data hold", mem_dq_oe, 1);
                w = mem.exists(int'(p_addr)) ? mem[int'(p_addr)] : 16'h0;
                if (!p_be_n[0]) w[7:0]  = p_dq[7:0];
                if (!p_be_n[1]) w[15:8] = p_dq[15:8];
                mem[int'(p_addr)] = w;
            end
            we_cnt = mem_we_n ? 0 : we_cnt + 1;
            oe_rel = !mem_oe_n ? 0 : oe_rel + 1;
            rd_cnt = (sel && !mem_oe_n && mem_we_n) ? rd_cnt + 1 : 0;
            if (rd_cnt >= E_RD) begin
                w = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0;
                mem_dq_in <= {mem_be_n[1] ? 8'h5A : w[15:8], mem_be_n[0] ? 8'hA5 : w[7:0]};
            end else begin
                mem_dq_in <= 16'hBAD0;
            end
            p_we_n  = mem_we_n;
            p_dq_oe = mem_dq_oe;
            p_be_n  = mem_be_n;
            p_addr  = mem_addr;
            p_dq    = mem_dq_out;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic access(input bit wr, input logic [18:0] a, input logic [15:0] d,
                          input logic [1:0] m, input logic [15:0] exp_rd);
        int n;
        @(negedge clk);
        chk(req_ready, "R8 ready when idle", req_ready, 1);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        n = 0;
        while (n < 60) begin
            @(negedge clk);
            req_valid = 0; req_wdata = 16'hFFFF; req_addr = '1;
            n++;
            if (rsp_done) break;
            if (req_ready) chk(0, "R8 ready while busy", n, 0);
        end
        chk(n == (wr ? E_WLAT : E_RLAT), "R9 done latency", n, wr ? E_WLAT : E_RLAT);
        if (!wr) chk(rsp_rdata == exp_rd, "R6 R7 read data", rsp_rdata, exp_rd);
        @(negedge clk);
        chk(!rsp_done, "R9 done pulse width", rsp_done, 0);
    endtask

    logic [15:0] shadow [16];
    logic [18:0] addrs  [16];

    initial begin
        for (int i = 0; i < 16; i++)
            addrs[i] = (i == 15) ? 19'h7FFFF : 19'(i * 19'h8423);
        repeat (3) @(negedge clk);
        chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 pins in reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        chk(req_ready && !rsp_done, "R1 handshake in reset", {req_ready, rsp_done}, 2'b10);
        rst = 0;
        @(negedge clk);
        chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
            "R1 after reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);

        // Full-word writes, then lane-mask writes (mask 0 must change nothing, R4).
        for (int i = 0; i < 16; i++) begin
            shadow[i] = 16'(addrs[i] * 3 + 16'h1357);
            access(1, addrs[i], shadow[i], 2'b11, 16'h0);
        end
        for (int i = 0; i < 16; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] d;
                d = 16'(~shadow[i] ^ (m * 16'h0F0F));
                access(1, addrs[i], d, 2'(m), 16'h0);
                if (m[0]) shadow[i][7:0]  = d[7:0];
                if (m[1]) shadow[i][15:8] = d[15:8];
            end
        end
        // Read back with every mask; unmasked lanes read zero (R7).
        for (int i = 0; i < 16; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] e;
                e = {m[1] ? shadow[i][15:8] : 8'h00, m[0] ? shadow[i][7:0] : 8'h00};
                access(0, addrs[i], 16'h0, 2'(m), e);
            end
        end
        // Write immediately followed by a read of the same word (R10 turnaround).
        access(1, addrs[3], 16'hC3A5, 2'b11, 16'h0);
        access(0, addrs[3], 16'h0, 2'b11, 16'hC3A5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule